// File: doc/BRIEF.md
# Timer-Attached Capture, Compare and PWM Unit

This block sits beside a free-running 16-bit timer. It works in one of three ways, selected by a 4-bit mode field. In capture it records the timer value when an external input changes. In compare it acts when the timer reaches a stored value. In PWM it produces a pulse-width modulated output, and the timer's period-match pulse marks the start of each period. One 16-bit data register holds the capture result, the compare value or the upper part of the PWM duty, depending on the mode.

Software programs the unit through a byte-wide register port: a control byte, the low data byte and the high data byte. It observes the unit through the interrupt flag, the driven pin and a timer-reset strobe.

In capture, the input passes through a two-flop synchroniser. Rising edges can be divided by 4 or by 16 before a capture takes place. In PWM, the 10-bit duty is compared against the timer's low byte extended by a 2-bit fine count. The unit takes a new duty value only at the start of a period.

Top module: `ccp_unit`

## Requirements
- R1: After reset, and whenever the mode field is 0000, the flag, pin_out, pin_oe and tmr_rst_stb are low. The data register reads zero and ignores writes.
- R2: Register map: address 0 is control {2'b00, duty_fine[1:0] at bits 5:4, mode[3:0] at bits 3:0}, address 1 is the data low byte and address 2 is the data high byte. Bits 7:6 of control and all of address 3 read as zero.
- R3: Mode 0100 loads the timer value into the data register and sets the flag on each falling input edge. This happens on the third rising clock edge after the input changes. Rising edges are ignored in this mode.
- R4: Mode 0101 captures on each rising input edge and ignores falling edges.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. A write that changes the mode clears the edge prescaler.
- R6: Mode 0010 toggles the driven pin and sets the flag on the first cycle that the timer equals the data register. A timer held at that value gives no further match.
- R7: Entering mode 1000 drives the pin low, and a match forces it high. Entering mode 1001 drives it high, and a match forces it low. Both set the flag.
- R8: In mode 1010 a match sets only the flag, and pin_oe stays low.
- R9: In mode 1011 a match sets the flag and raises tmr_rst_stb for exactly one cycle.
- R10: Modes 11xx run PWM with duty D = {data[7:0], duty_fine}. A period pulse raises the output, which then stays high for D clock cycles when the timer advances once every 4 clocks starting at 0.
- R11: In PWM, a duty at or above the period length in clocks keeps the output high for the whole period, and a duty of 0 keeps it low.
- R12: A duty change written during a PWM period takes effect only at the next period pulse.
- R13: Reserved modes 0001 and 0011 drive nothing and never set the flag. They keep the data register readable and writable.
- R14: flag_clr clears the flag. If a flag-setting event happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | 16 | Free-running timer value |
| tmr_prd_hit | input | 1 | Timer period-match pulse (PWM only) |
| cap_pin | input | 1 | External capture input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| flag_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Driven pin level (0 when not driven) |
| pin_oe | output | 1 | Pin drive enable |
| irq_flag | output | 1 | Interrupt flag |
| tmr_rst_stb | output | 1 | One-cycle timer-reset strobe |

## Verification
The five compare modes run from one table. A first match, a held-equal timer and a second match separate toggle behaviour from one-way forcing, from the flag-only mode and from the strobe-raising mode. The capture modes get rising and falling pulses. The capture timing separates falling from rising sensitivity, and a count of pulses just below and at the prescale limit shows whether the divider was cleared on a mode change. PWM runs with duties of 22, 13, 0 and above the period, and a duty write in the middle of a period shows whether the shadow register takes the new duty early or at the next period pulse.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  localparam int BUS_W  = 8;
  localparam int DATA_W = 16;
  localparam int DC_W   = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  localparam logic [3:0] M_OFF      = 4'b0000;
  localparam logic [3:0] M_TOGGLE   = 4'b0010;
  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_R1   = 4'b0101;
  localparam logic [3:0] M_CAP_R4   = 4'b0110;
  localparam logic [3:0] M_CAP_R16  = 4'b0111;
  localparam logic [3:0] M_SET_HI   = 4'b1000;
  localparam logic [3:0] M_SET_LO   = 4'b1001;
  localparam logic [3:0] M_FLAG     = 4'b1010;
  localparam logic [3:0] M_TRIG     = 4'b1011;

  typedef enum logic [2:0] {K_OFF, K_RSVD, K_CAP, K_CMP, K_PWM} ccp_kind_e;

  function automatic ccp_kind_e decode_kind(input logic [3:0] m);
    ccp_kind_e k;
    casez (m)
      4'b0000: k = K_OFF;
      4'b0010: k = K_CMP;
      4'b01??: k = K_CAP;
      4'b10??: k = K_CMP;
      4'b11??: k = K_PWM;
      default: k = K_RSVD;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/ccp_regs.sv
`timescale 1ns/1ps
module ccp_regs
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              cap_load,
  input  logic [DATA_W-1:0] cap_val,
  output logic [3:0]        mode_o,
  output logic [DC_W-1:0]   dc_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mode_chg_o,
  output logic [3:0]        mode_new_o
);
  logic [3:0]        mode_q, mode_d;
  logic [DC_W-1:0]   dc_q, dc_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              wr_ctrl, wr_lo, wr_hi;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_lo   = wr_en && (wr_addr == ADDR_LO);
  assign wr_hi   = wr_en && (wr_addr == ADDR_HI);

  always_comb begin
    mode_d = mode_q;
    dc_d   = dc_q;
    data_d = data_q;
    if (wr_ctrl) begin
      mode_d = wr_data[3:0];
      dc_d   = wr_data[4 +: DC_W];
    end
    if (mode_q == M_OFF)  data_d = '0;
    else if (wr_lo)       data_d[BUS_W-1:0] = wr_data;
    else if (wr_hi)       data_d[DATA_W-1:BUS_W] = wr_data;
    else if (cap_load)    data_d = cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dc_q   <= '0;
      data_q <= '0;
    end else begin
      mode_q <= mode_d;
      dc_q   <= dc_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = {2'b00, dc_q, mode_q};
      ADDR_LO:   rd_data = data_q[BUS_W-1:0];
      ADDR_HI:   rd_data = data_q[DATA_W-1:BUS_W];
      default:   rd_data = '0;
    endcase
  end

  assign mode_o     = mode_q;
  assign dc_o       = dc_q;
  assign data_o     = data_q;
  assign mode_chg_o = wr_ctrl && (wr_data[3:0] != mode_q);
  assign mode_new_o = wr_data[3:0];

  assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> (data_q == '0))
    else $error("data register not cleared in off mode");

  assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_load && mode_q != M_OFF && !wr_lo && !wr_hi) |=> (data_q == $past(cap_val)))
    else $error("capture did not load timer value");
endmodule

// File: rtl/ccp_capture.sv
`timescale 1ns/1ps
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_W     = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [3:0] mode,
  input  logic       pin_in,
  output logic       evt
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic [PRESC_W-1:0]     cnt_q, cnt_d, tgt;
  logic                   s_now, rise, fall, rise_mode;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    end else begin : g_single
      assign sync_d = pin_in;
    end
  endgenerate

  assign s_now     = sync_q[SYNC_STAGES-1];
  assign rise      = s_now & ~prev_q;
  assign fall      = ~s_now & prev_q;
  assign rise_mode = (mode == M_CAP_R1) || (mode == M_CAP_R4) || (mode == M_CAP_R16);

  always_comb begin
    case (mode)
      M_CAP_R4:  tgt = PRESC_W'(3);
      M_CAP_R16: tgt = PRESC_W'(15);
      default:   tgt = '0;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en || clr)             cnt_d = '0;
    else if (rise && rise_mode) cnt_d = (cnt_q == tgt) ? '0 : cnt_q + 1'b1;
  end

  assign evt = en && ((mode == M_CAP_FALL) ? fall : (rise_mode && rise && (cnt_q == tgt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= s_now;
      cnt_q  <= cnt_d;
    end
  end

  assert_presc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= tgt))
    else $error("capture prescaler beyond its limit");
endmodule

// File: rtl/ccp_compare.sv
`timescale 1ns/1ps
module ccp_compare
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] tmr,
  input  logic [DATA_W-1:0] cmp_val,
  output logic              evt
);
  logic eq, eq_q, eq_d;

  assign eq   = (tmr == cmp_val);
  assign eq_d = en ? eq : 1'b0;
  assign evt  = en && eq && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_d;
  end

  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt)
    else $error("compare match repeated on consecutive cycles");
endmodule

// File: rtl/ccp_pwm.sv
`timescale 1ns/1ps
module ccp_pwm #(
  parameter int DUTY_W = 10,
  parameter int FINE_W = 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     prd_hit,
  input  logic [DUTY_W-1:0]        duty,
  input  logic [DUTY_W-FINE_W-1:0] tmr_lo,
  output logic                     lvl
);
  logic [DUTY_W-1:0] shadow_q, shadow_d;
  logic [FINE_W-1:0] fine_q, fine_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    shadow_d = shadow_q;
    fine_d   = fine_q;
    lvl_d    = lvl_q;
    if (!en) begin
      shadow_d = '0;
      fine_d   = '0;
      lvl_d    = 1'b0;
    end else if (prd_hit) begin
      shadow_d = duty;
      fine_d   = FINE_W'(1);
      lvl_d    = (duty != '0);
    end else begin
      fine_d = fine_q + 1'b1;
      if ({tmr_lo, fine_q} == shadow_q) lvl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      fine_q   <= '0;
      lvl_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      fine_q   <= fine_d;
      lvl_q    <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !prd_hit) |=> $stable(shadow_q))
    else $error("duty shadow changed mid-period");
endmodule

// File: rtl/ccp_unit.sv
`timescale 1ns/1ps
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int DUTY_W      = 10,
  parameter int FINE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_W     = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tmr_val,
  input  logic              tmr_prd_hit,
  input  logic              cap_pin,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              flag_clr,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              tmr_rst_stb
);
  localparam int TLO_W = DUTY_W - FINE_W;
  localparam int DHI_W = DUTY_W - DC_W;

  logic [3:0]        mode_q, mode_new;
  logic [DC_W-1:0]   dc_q;
  logic [DATA_W-1:0] data_q;
  logic              mode_chg;
  ccp_kind_e         kind;
  logic              cap_evt, cmp_evt, pwm_lvl;
  logic              pin_q, pin_d, flag_q, flag_d, stb_q, stb_d;
  logic [DUTY_W-1:0] duty;

  assign kind = decode_kind(mode_q);
  assign duty = {data_q[DHI_W-1:0], dc_q};

  ccp_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .cap_load(cap_evt), .cap_val(tmr_val),
    .mode_o(mode_q), .dc_o(dc_q), .data_o(data_q),
    .mode_chg_o(mode_chg), .mode_new_o(mode_new)
  );

  ccp_capture #(.SYNC_STAGES(SYNC_STAGES), .PRESC_W(PRESC_W)) u_cap (
    .clk, .rst_n, .en(kind == K_CAP), .clr(mode_chg), .mode(mode_q),
    .pin_in(cap_pin), .evt(cap_evt)
  );

  ccp_compare u_cmp (
    .clk, .rst_n, .en(kind == K_CMP), .tmr(tmr_val), .cmp_val(data_q), .evt(cmp_evt)
  );

  ccp_pwm #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_pwm (
    .clk, .rst_n, .en(kind == K_PWM), .prd_hit(tmr_prd_hit), .duty(duty),
    .tmr_lo(tmr_val[TLO_W-1:0]), .lvl(pwm_lvl)
  );

  always_comb begin
    pin_d = pin_q;
    if (mode_chg)            pin_d = (mode_new == M_SET_LO);
    else if (kind == K_OFF)  pin_d = 1'b0;
    else if (cmp_evt) begin
      case (mode_q)
        M_TOGGLE: pin_d = ~pin_q;
        M_SET_HI: pin_d = 1'b1;
        M_SET_LO: pin_d = 1'b0;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (kind == K_OFF)           flag_d = 1'b0;
    else if (cap_evt || cmp_evt) flag_d = 1'b1;
    else if (flag_clr)           flag_d = 1'b0;
  end

  assign stb_d = cmp_evt && (mode_q == M_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= flag_d;
      stb_q  <= stb_d;
    end
  end

  assign pin_oe      = ((kind == K_CMP) && (mode_q != M_FLAG)) || (kind == K_PWM);
  assign pin_out     = pin_oe && ((kind == K_PWM) ? pwm_lvl : pin_q);
  assign irq_flag    = flag_q;
  assign tmr_rst_stb = stb_q;

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_OFF && !mode_chg) |=> (!irq_flag && !pin_out && !tmr_rst_stb))
    else $error("off mode not quiet");

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && mode_q == M_TOGGLE && !mode_chg) |=> (pin_q != $past(pin_q)))
    else $error("toggle mode did not invert pin");

  assert_trig_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst_stb |-> ($past(mode_q) == M_TRIG))
    else $error("timer-reset strobe outside trigger mode");
endmodule

// File: tb/tb_ccp_unit.sv
`timescale 1ns/1ps
module tb_ccp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr_val;
  logic        tmr_prd_hit, cap_pin, wr_en, flag_clr;
  logic [1:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic        pin_out, pin_oe, irq_flag, tmr_rst_stb;

  int n_checks = 0;
  int n_err    = 0;

  always #2.5 clk = ~clk;

  ccp_unit dut (
    .clk, .rst_n, .tmr_val, .tmr_prd_hit, .cap_pin, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .flag_clr, .pin_out, .pin_oe, .irq_flag, .tmr_rst_stb
  );

  // {mode, init_out, init_oe, post_out, post_oe, post_flag, post_stb, second_out}
  localparam logic [10:0] CMP_TAB [5] = '{
    {4'b0010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'b1001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'b1011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic pulse_pin();
    cap_pin = 1'b1; tick(4); cap_pin = 1'b0; tick(4);
  endtask

  task automatic run_period(input int p, input bit do_wr, input logic [7:0] wv, output int hi);
    hi = 0;
    for (int c = 0; c < 4 * p; c++) begin
      tmr_prd_hit = (c == 0);
      tmr_val = 16'(c >> 2);
      if (do_wr && c == 5) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = wv;
      end else wr_en = 1'b0;
      @(negedge clk);
      if (pin_out) hi++;
    end
    tmr_prd_hit = 1'b0;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    int hi;
    rst_n = 1'b0; tmr_val = 16'hFFFF; tmr_prd_hit = 1'b0; cap_pin = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; flag_clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state and off-mode write blocking
    rd(0, r);  chk("R1", "ctrl after reset", r, 0);
    chk("R1", "pin_out", pin_out, 0);
    chk("R1", "pin_oe", pin_oe, 0);
    chk("R1", "flag", irq_flag, 0);
    chk("R1", "strobe", tmr_rst_stb, 0);
    wr(1, 8'h55);
    rd(1, r);  chk("R1", "data write in off mode", r, 0);

    // R2 control read-back and map
    wr(0, 8'hFA);
    rd(0, r);  chk("R2", "ctrl top bits", r, 8'h3A);
    rd(3, r);  chk("R2", "address 3", r, 0);
    wr(0, 8'h00);

    // R6 R7 R8 R9 compare table
    for (int i = 0; i < 5; i++) begin
      logic [10:0] e;
      e = CMP_TAB[i];
      tmr_val = 16'hFFFF;
      wr(0, 8'h00);
      wr(0, {4'b0000, e[10:7]});
      wr(1, 8'h22);
      wr(2, 8'h11);
      chk("R7", $sformatf("init out mode %b", e[10:7]), pin_out, e[6]);
      chk("R8", $sformatf("init oe mode %b", e[10:7]), pin_oe, e[5]);
      tmr_val = 16'h1122;
      tick(1);
      chk("R6", $sformatf("match out mode %b", e[10:7]), pin_out, e[4]);
      chk("R8", $sformatf("match oe mode %b", e[10:7]), pin_oe, e[3]);
      chk("R6", $sformatf("match flag mode %b", e[10:7]), irq_flag, e[2]);
      chk("R9", $sformatf("strobe mode %b", e[10:7]), tmr_rst_stb, e[1]);
      tick(1);
      chk("R9", $sformatf("strobe one cycle mode %b", e[10:7]), tmr_rst_stb, 0);
      chk("R6", $sformatf("held equal mode %b", e[10:7]), pin_out, e[4]);
      tmr_val = 16'h0000;
      tick(1);
      tmr_val = 16'h1122;
      tick(1);
      chk("R7", $sformatf("second match mode %b", e[10:7]), pin_out, e[0]);
    end

    // R3 falling-edge capture
    wr(0, 8'h00);
    wr(0, 8'h04);
    tmr_val = 16'hBEEF; cap_pin = 1'b1; tick(4);
    chk("R3", "rise ignored", irq_flag, 0);
    tmr_val = 16'h1234; cap_pin = 1'b0; tick(2);
    chk("R3", "not before third edge", irq_flag, 0);
    tick(1);
    chk("R3", "flag on fall", irq_flag, 1);
    rd(1, r); rd(2, r2);
    chk("R3", "captured value", {r2, r}, 16'h1234);

    // R4 rising-edge capture
    wr(0, 8'h05);
    clr_flag();
    tmr_val = 16'h0A0B; cap_pin = 1'b1; tick(4);
    rd(1, r); rd(2, r2);
    chk("R4", "rise capture", {r2, r}, 16'h0A0B);
    tmr_val = 16'h7777; cap_pin = 1'b0; tick(4);
    rd(1, r); rd(2, r2);
    chk("R4", "fall ignored", {r2, r}, 16'h0A0B);

    // R5 prescaled capture and clearing on mode change
    wr(0, 8'h06);
    clr_flag();
    tmr_val = 16'h4444;
    repeat (3) pulse_pin();
    chk("R5", "three rises no capture", irq_flag, 0);
    pulse_pin();
    chk("R5", "fourth rise captures", irq_flag, 1);
    rd(1, r); rd(2, r2);
    chk("R5", "divide-by-4 value", {r2, r}, 16'h4444);
    clr_flag();
    repeat (2) pulse_pin();
    wr(0, 8'h07);
    repeat (15) pulse_pin();
    chk("R5", "prescaler cleared on mode change", irq_flag, 0);
    pulse_pin();
    chk("R5", "sixteenth rise captures", irq_flag, 1);

    // R13 reserved mode
    wr(0, 8'h01);
    clr_flag();
    wr(1, 8'hAB);
    wr(2, 8'hCD);
    rd(1, r); rd(2, r2);
    chk("R13", "data writable", {r2, r}, 16'hCDAB);
    tmr_val = 16'hCDAB; tick(2);
    chk("R13", "no drive", pin_oe, 0);
    pulse_pin();
    chk("R13", "no flag", irq_flag, 0);
    rd(1, r); rd(2, r2);
    chk("R13", "data kept", {r2, r}, 16'hCDAB);

    // R14 flag clear and set priority
    wr(0, 8'h00);
    tmr_val = 16'hFFFF;
    wr(0, 8'h0A);
    wr(1, 8'h00);
    wr(2, 8'h01);
    tmr_val = 16'h0100; tick(1);
    chk("R14", "flag set", irq_flag, 1);
    clr_flag();
    chk("R14", "flag cleared", irq_flag, 0);
    tmr_val = 16'h0000; tick(1);
    tmr_val = 16'h0100; flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R14", "set wins over clear", irq_flag, 1);

    // R10 R11 R12 PWM
    wr(0, 8'h00);
    wr(0, 8'h2C);
    wr(1, 8'h05);
    run_period(16, 1'b0, 8'h00, hi);
    run_period(16, 1'b0, 8'h00, hi);
    chk("R10", "duty 22 high cycles", hi, 22);
    chk("R10", "pwm drives pin", pin_oe, 1);
    wr(1, 8'h40);
    run_period(16, 1'b0, 8'h00, hi);
    run_period(16, 1'b0, 8'h00, hi);
    chk("R11", "duty above period", hi, 64);
    wr(1, 8'h00);
    wr(0, 8'h0C);
    run_period(16, 1'b0, 8'h00, hi);
    run_period(16, 1'b0, 8'h00, hi);
    chk("R11", "duty zero", hi, 0);
    wr(0, 8'h2C);
    wr(1, 8'h05);
    run_period(16, 1'b0, 8'h00, hi);
    run_period(16, 1'b1, 8'h0A, hi);
    chk("R12", "mid-period write deferred", hi, 22);
    run_period(16, 1'b0, 8'h00, hi);
    chk("R12", "new duty next period", hi, 42);
    wr(0, 8'h1F);
    wr(1, 8'h03);
    run_period(16, 1'b0, 8'h00, hi);
    run_period(16, 1'b0, 8'h00, hi);
    chk("R10", "mode 1111 duty 13", hi, 13);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule